// File: doc/BRIEF.md
# Cipher Extended-Mode Control Register with Private-Key Lock

This block is one 32-bit control register of a block-cipher engine, reached over a simple register bus. It stores the engine's extended-mode settings: the padding controls, the protocol-layer acceleration controls, the next-header byte, the key source and the block-reporting choice. It also guards a 256-bit private-key bank that is loaded through a separate side port. A sticky lock makes that bank write-once until the next hardware reset.

The block registers the key that feeds the cipher. That key comes either from the bus-written key registers, which enter as `sw_key`, or from the private bank. The block also keeps the data-ready flag. That flag can be raised once per processed block or only when the whole message is done, and software can ask for it when it supplies blocks by hand. The cipher and padding datapaths sit outside this block. Their block-end and message-end pulses drive the flag.

Top module: `cipher_xmode_ctrl`

## Requirements
- R1: After a synchronous reset, every stored field is zero, the lock is released, `data_ready` is 0 and `cipher_key` is 0 until the first clock after reset releases.
- R2: A bus write to offset 0xB0 stores the fields at fixed bits: 31 block-report, 23:16 next-header, 15:8 pad length, 7 key source, 5 decipher, 4 protocol enable, 1 pad mode (1 = SSL, 0 = IPsec), 0 pad enable. A read at 0xB0 returns them on `bus_rdata` one cycle after `bus_rd`, with all other bits 0. Writes to other offsets change nothing. Reads at other offsets, and cycles without a read, give 0.
- R3: While `wr_protect` is 1, bus writes change no field and do not set the lock.
- R4: Writing 1 to bit 6 sets an internal key lock that stays set until reset, whatever is written later. Bit 6 always reads as 0.
- R5: While unlocked, every `pk_valid` word is stored, so the bank can be reloaded any number of times. Word i (`pk_index` = i) occupies key bits 32*i+31 to 32*i.
- R6: While locked, the bank accepts words only until the word with index 7 is stored. After that, all port writes are dropped until reset. Loads made before locking do not count.
- R7: `cipher_key` is registered. One cycle after the bank or `sw_key` changes, it shows the private bank when key source is 1 and `sw_key` when key source is 0.
- R8: A `blk_end` pulse raises `data_ready` only when block-report is 1 and `stream_mode` is 2. Otherwise it is ignored.
- R9: A `msg_end` pulse always raises `data_ready`.
- R10: An accepted bus write with bit 31 set raises `data_ready` when block-report is already 1 and `stream_mode` is 2.
- R11: `status_rd` or `data_wr` clears `data_ready`. When a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data |
| wr_protect | input | 1 | Write-protect enable; blocks bus writes |
| stream_mode | input | 2 | Engine start mode; 2 selects block-by-block operation |
| pk_valid | input | 1 | Private-key word valid |
| pk_index | input | 3 | Private-key word index |
| pk_data | input | 32 | Private-key word |
| sw_key | input | 256 | Key from the bus-written key registers |
| cipher_key | output | 256 | Registered key to the cipher |
| blk_end | input | 1 | Pulse: one block processed |
| msg_end | input | 1 | Pulse: whole message processed |
| status_rd | input | 1 | Status register read; clears ready |
| data_wr | input | 1 | New input data written; clears ready |
| data_ready | output | 1 | Data-ready flag |
| pad_en | output | 1 | Auto padding enable |
| pad_ssl | output | 1 | Padding style: 1 SSL, 0 IPsec |
| proto_en | output | 1 | Protocol-layer acceleration enable |
| proto_dec | output | 1 | Protocol layer deciphers when 1 |
| pad_len | output | 8 | Padding length in bytes |
| next_hdr | output | 8 | IPsec next-header byte |
| key_src | output | 1 | Key source: 1 private bank, 0 sw_key |

## Verification
The bench covers the lock edge cases. It checks that a write of 0 to the lock does not release it, which would let a second private key overwrite the first. It checks that a load made before locking does not use up the one permitted load, and that the lock reads back as 0 yet is cleared by reset alone. It checks the ready flag's gating: `blk_end` outside block mode, or with block-report clear, must leave the flag low. It also checks that a block-report write raises the flag only when the bit was already set, and that a set and a clear in the same cycle leave the flag high. A flawed design would lose an event or raise a spurious one. Writes under write-protect and writes to a neighbouring offset must leave every field unchanged.

// File: rtl/xm_pkg.sv
package xm_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned BPE_B    = 31;
  localparam int unsigned NHDR_LO  = 16;
  localparam int unsigned PLEN_LO  = 8;
  localparam int unsigned KSEL_B   = 7;
  localparam int unsigned LOCK_B   = 6;
  localparam int unsigned PDEC_B   = 5;
  localparam int unsigned PEN_B    = 4;
  localparam int unsigned PMODE_B  = 1;
  localparam int unsigned PAD_B    = 0;

  typedef struct packed {
    logic       bpe;
    logic [7:0] nhdr;
    logic [7:0] padlen;
    logic       ksel;
    logic       pdec;
    logic       pen;
    logic       pmode;
    logic       paden;
  } xm_fields_t;

  function automatic logic [REG_W-1:0] xm_image(xm_fields_t f);
    logic [REG_W-1:0] v;
    v = '0;
    v[BPE_B]           = f.bpe;
    v[NHDR_LO +: 8]    = f.nhdr;
    v[PLEN_LO +: 8]    = f.padlen;
    v[KSEL_B]          = f.ksel;
    v[PDEC_B]          = f.pdec;
    v[PEN_B]           = f.pen;
    v[PMODE_B]         = f.pmode;
    v[PAD_B]           = f.paden;
    return v;
  endfunction

  function automatic xm_fields_t xm_decode(logic [REG_W-1:0] w);
    xm_fields_t f;
    f.bpe    = w[BPE_B];
    f.nhdr   = w[NHDR_LO +: 8];
    f.padlen = w[PLEN_LO +: 8];
    f.ksel   = w[KSEL_B];
    f.pdec   = w[PDEC_B];
    f.pen    = w[PEN_B];
    f.pmode  = w[PMODE_B];
    f.paden  = w[PAD_B];
    return f;
  endfunction
endpackage

// File: rtl/xm_regfile.sv
module xm_regfile
  import xm_pkg::*;
#(
  parameter int unsigned        ADDR_W  = 8,
  parameter logic [ADDR_W-1:0]  REG_OFS = 8'hB0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              wr_protect,
  output xm_fields_t        cfg,
  output logic              key_lock,
  output logic              bpe_req,
  output logic [REG_W-1:0]  bus_rdata
);
  logic hit;
  logic wr_ok;
  logic unused_wbits;

  assign hit    = (bus_addr == REG_OFS);
  assign wr_ok  = bus_wr && hit && !wr_protect;
  // request for a fresh block: bit written high while already reporting per block
  assign bpe_req = wr_ok && bus_wdata[BPE_B] && cfg.bpe;
  assign unused_wbits = ^{bus_wdata[30:24], bus_wdata[3:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      key_lock  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ok) begin
        cfg <= xm_decode(bus_wdata);
        if (bus_wdata[LOCK_B]) key_lock <= 1'b1;
      end
      bus_rdata <= (bus_rd && hit) ? xm_image(cfg) : '0;
    end
  end
endmodule

// File: rtl/xm_keybank.sv
module xm_keybank #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WW    = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_lock,
  input  logic               pk_valid,
  input  logic [IDX_W-1:0]   pk_index,
  input  logic [WW-1:0]      pk_data,
  output logic               pk_we,
  output logic               pk_loaded,
  output logic [WORDS*WW-1:0] bank_flat
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [WW-1:0] mem [WORDS];

  assign pk_we = pk_valid && (!key_lock || !pk_loaded);

  always_ff @(posedge clk) begin
    if (pk_we) mem[pk_index] <= pk_data;
  end

  always_ff @(posedge clk) begin
    if (rst || !key_lock)
      pk_loaded <= 1'b0;
    else if (pk_we && pk_index == LAST_IDX)
      pk_loaded <= 1'b1;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign bank_flat[g*WW +: WW] = mem[g];
  end
endmodule

// File: rtl/xm_ready.sv
module xm_ready #(
  parameter int unsigned MODE_W   = 2,
  parameter int unsigned BLK_MODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bpe,
  input  logic [MODE_W-1:0] stream_mode,
  input  logic              blk_end,
  input  logic              msg_end,
  input  logic              bpe_req,
  input  logic              status_rd,
  input  logic              data_wr,
  output logic              data_ready
);
  logic blk_mode;
  logic set_rdy;
  logic clr_rdy;

  assign blk_mode = (stream_mode == MODE_W'(BLK_MODE));
  assign set_rdy  = msg_end || (blk_mode && bpe && (blk_end || bpe_req));
  assign clr_rdy  = status_rd || data_wr;

  always_ff @(posedge clk) begin
    if (rst)          data_ready <= 1'b0;
    else if (set_rdy) data_ready <= 1'b1;
    else if (clr_rdy) data_ready <= 1'b0;
  end
endmodule

// File: rtl/cipher_xmode_ctrl.sv
module cipher_xmode_ctrl
  import xm_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  REG_OFS   = 8'hB0,
  parameter int unsigned        KEY_WORDS = 8,
  parameter int unsigned        KEY_WW    = 32,
  parameter int unsigned        MODE_W    = 2,
  parameter int unsigned        BLK_MODE  = 2,
  localparam int unsigned       IDX_W     = $clog2(KEY_WORDS),
  localparam int unsigned       KEY_W     = KEY_WORDS * KEY_WW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wr_protect,
  input  logic [MODE_W-1:0] stream_mode,
  input  logic              pk_valid,
  input  logic [IDX_W-1:0]  pk_index,
  input  logic [KEY_WW-1:0] pk_data,
  input  logic [KEY_W-1:0]  sw_key,
  output logic [KEY_W-1:0]  cipher_key,
  input  logic              blk_end,
  input  logic              msg_end,
  input  logic              status_rd,
  input  logic              data_wr,
  output logic              data_ready,
  output logic              pad_en,
  output logic              pad_ssl,
  output logic              proto_en,
  output logic              proto_dec,
  output logic [7:0]        pad_len,
  output logic [7:0]        next_hdr,
  output logic              key_src
);
  xm_fields_t       cfg;
  logic             key_lock;
  logic             bpe_req;
  logic             pk_we;
  logic             pk_loaded;
  logic [KEY_W-1:0] bank_flat;

  xm_regfile #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wr_protect(wr_protect),
    .cfg(cfg), .key_lock(key_lock), .bpe_req(bpe_req), .bus_rdata(bus_rdata)
  );

  xm_keybank #(.WORDS(KEY_WORDS), .WW(KEY_WW)) u_bank (
    .clk(clk), .rst(rst), .key_lock(key_lock), .pk_valid(pk_valid),
    .pk_index(pk_index), .pk_data(pk_data), .pk_we(pk_we),
    .pk_loaded(pk_loaded), .bank_flat(bank_flat)
  );

  xm_ready #(.MODE_W(MODE_W), .BLK_MODE(BLK_MODE)) u_rdy (
    .clk(clk), .rst(rst), .bpe(cfg.bpe), .stream_mode(stream_mode),
    .blk_end(blk_end), .msg_end(msg_end), .bpe_req(bpe_req),
    .status_rd(status_rd), .data_wr(data_wr), .data_ready(data_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) cipher_key <= '0;
    else     cipher_key <= cfg.ksel ? bank_flat : sw_key;
  end

  assign pad_en    = cfg.paden;
  assign pad_ssl   = cfg.pmode;
  assign proto_en  = cfg.pen;
  assign proto_dec = cfg.pdec;
  assign pad_len   = cfg.padlen;
  assign next_hdr  = cfg.nhdr;
  assign key_src   = cfg.ksel;
endmodule

// File: rtl/xm_checker.sv
module xm_checker
  import xm_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        wr_protect,
  input xm_fields_t  cfg,
  input logic        key_lock,
  input logic        pk_we,
  input logic        pk_loaded,
  input logic        msg_end,
  input logic        data_ready,
  input logic [31:0] bus_rdata
);
  // R2: read data is zero in any cycle that follows no read
  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  // R3: a protected write leaves the fields as they were
  assert_wp_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && wr_protect) |=> $stable(cfg));

  // R4: the lock stays set until reset
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    key_lock |=> key_lock);

  // R6: once a locked load is complete the bank takes no writes
  assert_locked_once_R6: assert property (@(posedge clk) disable iff (rst)
    (key_lock && pk_loaded) |-> !pk_we);

  // R6: the completed-load mark exists only under the lock
  assert_loaded_needs_lock_R6: assert property (@(posedge clk) disable iff (rst)
    pk_loaded |-> key_lock);

  // R9: message end always raises ready
  assert_msg_ready_R9: assert property (@(posedge clk) disable iff (rst)
    msg_end |=> data_ready);
endmodule

bind cipher_xmode_ctrl xm_checker u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .wr_protect(wr_protect), .cfg(cfg), .key_lock(key_lock), .pk_we(pk_we),
  .pk_loaded(pk_loaded), .msg_end(msg_end), .data_ready(data_ready),
  .bus_rdata(bus_rdata)
);

// File: tb/test_cipher_xmode_ctrl.sv
module test_cipher_xmode_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = 8'h00;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         wr_protect = 1'b0;
  logic [1:0]   stream_mode = 2'd0;
  logic         pk_valid = 1'b0;
  logic [2:0]   pk_index = '0;
  logic [31:0]  pk_data = '0;
  logic [255:0] sw_key = '0;
  logic [255:0] cipher_key;
  logic         blk_end = 1'b0, msg_end = 1'b0, status_rd = 1'b0, data_wr = 1'b0;
  logic         data_ready;
  logic         pad_en, pad_ssl, proto_en, proto_dec, key_src;
  logic [7:0]   pad_len, next_hdr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cipher_xmode_ctrl i_cipher_xmode_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_protect(wr_protect), .stream_mode(stream_mode),
    .pk_valid(pk_valid), .pk_index(pk_index), .pk_data(pk_data),
    .sw_key(sw_key), .cipher_key(cipher_key), .blk_end(blk_end),
    .msg_end(msg_end), .status_rd(status_rd), .data_wr(data_wr),
    .data_ready(data_ready), .pad_en(pad_en), .pad_ssl(pad_ssl),
    .proto_en(proto_en), .proto_dec(proto_dec), .pad_len(pad_len),
    .next_hdr(next_hdr), .key_src(key_src)
  );

  localparam int NV = 6;
  localparam logic [31:0] TV_W [NV] = '{32'hFFFF_FFBF, 32'h1234_5638,
    32'h8000_0000, 32'h0000_0083, 32'h7F00_0000, 32'h00AA_5512};
  localparam logic [31:0] TV_E [NV] = '{32'h80FF_FFB3, 32'h0034_5630,
    32'h8000_0000, 32'h0000_0083, 32'h0000_0000, 32'h00AA_5512};

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic load(logic [255:0] k);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); pk_valid = 1'b1; pk_index = 3'(i); pk_data = k[i*32 +: 32];
    end
    @(negedge clk); pk_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [255:0] pat(logic [7:0] s);
    logic [255:0] k;
    for (int i = 0; i < 8; i++) k[i*32 +: 32] = {s, 8'(i), ~s, 8'(i * 3)};
    return k;
  endfunction

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R1 ready at reset", 256'(data_ready), 256'(0));
    check("R1 key at reset", cipher_key, '0);
    rst = 1'b0;
    rd(8'hB0, r);
    check("R1 fields after reset", 256'(r), 256'(0));

    for (int i = 0; i < NV; i++) begin
      wr(8'hB0, TV_W[i]);
      rd(8'hB0, r);
      check("R2 field readback", 256'(r), 256'(TV_E[i]));
    end
    check("R2 pad_len port", 256'(pad_len), 256'(8'h55));
    check("R2 next_hdr port", 256'(next_hdr), 256'(8'hAA));

    wr(8'hB4, 32'hFFFF_FFBF);
    rd(8'hB0, r);
    check("R2 other offset write ignored", 256'(r), 256'(32'h00AA_5512));
    rd(8'hB4, r);
    check("R2 other offset reads zero", 256'(r), 256'(0));

    wr_protect = 1'b1;
    wr(8'hB0, 32'h0011_0040);
    wr_protect = 1'b0;
    rd(8'hB0, r);
    check("R3 protected write ignored", 256'(r), 256'(32'h00AA_5512));

    // unlocked bank: reload twice (also proves protected write set no lock)
    wr(8'hB0, 32'h0000_0080);
    load(pat(8'h11));
    check("R5 first unlocked load", cipher_key, pat(8'h11));
    load(pat(8'h22));
    check("R5 reload while unlocked", cipher_key, pat(8'h22));
    sw_key = pat(8'h5A);
    wr(8'hB0, 32'h0000_0000);
    @(negedge clk);
    check("R7 sw key routed", cipher_key, pat(8'h5A));

    wr(8'hB0, 32'h0000_00C0);
    rd(8'hB0, r);
    check("R4 lock reads zero", 256'(r), 256'(32'h0000_0080));
    wr(8'hB0, 32'h0000_0080);
    load(pat(8'h33));
    check("R6 one load after lock", cipher_key, pat(8'h33));
    load(pat(8'h44));
    check("R6 second locked load dropped R4", cipher_key, pat(8'h33));

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(8'hB0, r);
    check("R1 fields after second reset", 256'(r), 256'(0));
    wr(8'hB0, 32'h0000_0080);
    load(pat(8'h55));
    load(pat(8'h66));
    check("R4 reset releases lock", cipher_key, pat(8'h66));

    stream_mode = 2'd2;
    wr(8'hB0, 32'h8000_0000);
    check("R10 first bpe write no ready", 256'(data_ready), 256'(0));
    pulse(blk_end);
    check("R8 block end raises ready", 256'(data_ready), 256'(1));
    pulse(status_rd);
    check("R11 status read clears", 256'(data_ready), 256'(0));
    wr(8'hB0, 32'h8000_0000);
    check("R10 bpe request raises ready", 256'(data_ready), 256'(1));
    pulse(data_wr);
    check("R11 data write clears", 256'(data_ready), 256'(0));
    stream_mode = 2'd1;
    pulse(blk_end);
    check("R8 block end ignored outside mode 2", 256'(data_ready), 256'(0));
    wr(8'hB0, 32'h8000_0000);
    check("R10 request ignored outside mode 2", 256'(data_ready), 256'(0));
    pulse(msg_end);
    check("R9 message end raises ready", 256'(data_ready), 256'(1));
    @(negedge clk); msg_end = 1'b1; status_rd = 1'b1;
    @(negedge clk); msg_end = 1'b0; status_rd = 1'b0;
    check("R11 set wins over clear", 256'(data_ready), 256'(1));
    pulse(status_rd);
    wr(8'hB0, 32'h0000_0000);
    stream_mode = 2'd2;
    pulse(blk_end);
    check("R8 block end ignored with bpe 0", 256'(data_ready), 256'(0));
    pulse(msg_end);
    check("R9 message end with bpe 0", 256'(data_ready), 256'(1));

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule